// File: doc/BRIEF.md
# Serial Input Expander Reader

This block reads a chain of external parallel-in/serial-out 8-bit shift registers and turns its contents into a stream of byte writes. When idle it holds the chain in capture mode: the active-low capture strobe is low and the shift clock is high. A start request first keeps the strobe low for at least one divided period, so that every parallel input is captured at once. It then raises the strobe and runs the shift clock. One bit is taken from the serial data line in each high phase. Bits are packed into bytes with the first bit received ending up as the most significant bit.

The number of chained devices is given as a run-time count and is sampled at the start request. The block reads eight bits per device and writes one byte per device to a write port, with ascending indices from zero. After the final bit the strobe goes low again, so the chain is back in capture mode. A one-cycle done pulse follows the last byte write. The serial line passes through a two-flop synchronizer. The bit is therefore sampled in the last system cycle of each shift-clock high phase. By that point a value the chain changed on the preceding rising edge has reached the sampling flop.

Top module: `sxr_reader`

## Requirements
- R1: After reset, load_n is 0, shift_clk is 1, and busy, done and wr_en are all 0.
- R2: A start request with a non-zero count sets busy in the next cycle. load_n then stays low for exactly HALF_CYCLES cycles after the start edge and rises while shift_clk is high. shift_clk is high whenever load_n is low.
- R3: Every low phase and every high phase of shift_clk lasts HALF_CYCLES system cycles. A run of N devices makes exactly 8*N-1 rising shift_clk edges. shift_clk falls only while load_n is high and busy is 1.
- R4: Bits are packed MSB-first. The first bit read in a byte lands in wr_data[7] and the eighth bit read lands in wr_data[0].
- R5: A run writes exactly N bytes with wr_en pulses, at wr_idx 0, 1, ..., N-1 in that order. Byte k holds serial bits 8k to 8k+7. A count above MAX_DEV is treated as MAX_DEV.
- R6: When a run ends, load_n is 0 and shift_clk is 1.
- R7: done is a single-cycle pulse. It comes in the cycle after the last wr_en pulse, and busy is 0 from that cycle on.
- R8: A start request while busy is 1 is ignored. Neither the run in progress nor its sampled count changes, and no second run follows.
- R9: A start request with a count of 0 gives done in the next cycle. It gives no load_n high pulse, no shift_clk edge and no write, and busy stays 0.
- R10: ser_in is read through a two-stage synchronizer in the last cycle of each high phase. Data that changes up to one system cycle after a rising shift_clk edge is still read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one read pass of the chain |
| dev_count | input | CNT_W | Number of chained 8-bit devices, sampled at start |
| ser_in | input | 1 | Serial data from the last stage of the chain |
| load_n | output | 1 | Active-low parallel capture strobe to the chain |
| shift_clk | output | 1 | Shift clock to the chain |
| wr_en | output | 1 | Byte write strobe |
| wr_idx | output | IDX_W | Byte index of the current write |
| wr_data | output | 8 | Assembled byte |
| busy | output | 1 | A read pass is in progress |
| done | output | 1 | One-cycle pulse after the last byte write |

## Verification
A wrong phase count or a wrong state transition shows up within one shift-clock phase: a high or low time differs from HALF_CYCLES, or the number of rising edges per run is off. A fault in the bit counter or the byte index shows up at the first write of a run as a wrong wr_idx, a shifted wr_data or a missing write. A synchronizer or sample point that is too early gives a wrong byte value, because the bench's chain model updates its serial output one system cycle after each rising shift-clock edge. A fault in idle handling shows at once as a stray done, a load_n pulse when the count is zero, or a second run after a start request that arrived while busy.

// File: rtl/sxr_pkg.sv
package sxr_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] sxr_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HIGH,
        ST_LOW,
        ST_FIN
    } sxr_state_e;

    // Pin pair driven towards the external chain
    typedef struct packed {
        logic load_n;
        logic sclk;
    } sxr_pins_t;

    // Append a bit at the least significant end
    function automatic sxr_byte_t push_lsb(input sxr_byte_t cur, input logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/sxr_sync.sv
module sxr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sxr_phase_timer.sv
module sxr_phase_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic last
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (last)      cnt_q <= '0;
        else                cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/sxr_assembler.sv
module sxr_assembler
    import sxr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      take,
    input  logic      bit_in,
    output logic      full,
    output sxr_byte_t value
);
    localparam int BW = $clog2(BYTE_W);

    sxr_byte_t     acc_q;
    logic [BW-1:0] cnt_q;

    assign value = push_lsb(acc_q, bit_in);
    assign full  = take && (cnt_q == BW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= value;
            cnt_q <= cnt_q + BW'(1);
        end
    end
endmodule

// File: rtl/sxr_ctrl.sv
module sxr_ctrl
    import sxr_pkg::*;
#(
    parameter int MAX_DEV = 4,
    parameter int CNT_W   = 3,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] dev_count,
    input  logic             phase_last,
    input  logic             byte_full,
    input  sxr_byte_t        byte_val,
    output logic             timer_restart,
    output logic             take_bit,
    output logic             load_n,
    output logic             shift_clk,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output sxr_byte_t        wr_data
);
    sxr_state_e       state_q;
    sxr_pins_t        pins_q;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] n_eff;
    logic             last_byte;

    assign n_eff = (dev_count > CNT_W'(MAX_DEV)) ? CNT_W'(MAX_DEV) : dev_count;
    assign last_byte = (idx_q == n_q - CNT_W'(1));

    assign timer_restart = (state_q == ST_IDLE);
    assign take_bit      = (state_q == ST_HIGH) && phase_last;
    assign load_n        = pins_q.load_n;
    assign shift_clk     = pins_q.sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= '{load_n: 1'b0, sclk: 1'b1};
            n_q     <= '0;
            idx_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            done  <= 1'b0;
            wr_en <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (n_eff == '0) begin
                            done <= 1'b1;
                        end else begin
                            n_q     <= n_eff;
                            idx_q   <= '0;
                            busy    <= 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (phase_last) begin
                        pins_q.load_n <= 1'b1;
                        state_q       <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (phase_last) begin
                        if (byte_full) begin
                            wr_en   <= 1'b1;
                            wr_data <= byte_val;
                            wr_idx  <= idx_q[IDX_W-1:0];
                        end
                        if (byte_full && last_byte) begin
                            pins_q.load_n <= 1'b0;
                            state_q       <= ST_FIN;
                        end else begin
                            if (byte_full) idx_q <= idx_q + CNT_W'(1);
                            pins_q.sclk <= 1'b0;
                            state_q     <= ST_LOW;
                        end
                    end
                end
                ST_LOW: begin
                    if (phase_last) begin
                        pins_q.sclk <= 1'b1;
                        state_q     <= ST_HIGH;
                    end
                end
                ST_FIN: begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sxr_reader.sv
module sxr_reader
    import sxr_pkg::*;
#(
    parameter int  MAX_DEV     = 4,
    parameter int  HALF_CYCLES = 4,
    parameter int  SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(MAX_DEV + 1),
    localparam int IDX_W       = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] dev_count,
    input  logic             ser_in,
    output logic             load_n,
    output logic             shift_clk,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done
);
    // The sample point must come after the synchronizer latency
    localparam int HALF_EFF = (HALF_CYCLES < SYNC_STAGES + 1) ? SYNC_STAGES + 1 : HALF_CYCLES;

    logic      ser_sync;
    logic      phase_last;
    logic      timer_restart;
    logic      take_bit;
    logic      byte_full;
    sxr_byte_t byte_val;

    sxr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ser_in),
        .q   (ser_sync)
    );

    sxr_phase_timer #(.HALF(HALF_EFF)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (timer_restart),
        .last    (phase_last)
    );

    sxr_assembler u_asm (
        .clk    (clk),
        .rst    (rst),
        .clear  (timer_restart),
        .take   (take_bit),
        .bit_in (ser_sync),
        .full   (byte_full),
        .value  (byte_val)
    );

    sxr_ctrl #(.MAX_DEV(MAX_DEV), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .dev_count     (dev_count),
        .phase_last    (phase_last),
        .byte_full     (byte_full),
        .byte_val      (byte_val),
        .timer_restart (timer_restart),
        .take_bit      (take_bit),
        .load_n        (load_n),
        .shift_clk     (shift_clk),
        .busy          (busy),
        .done          (done),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data)
    );
endmodule

// File: rtl/sxr_reader_chk.sv
module sxr_reader_chk #(
    parameter int HALF  = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] dev_count,
    input logic             load_n,
    input logic             shift_clk,
    input logic             wr_en,
    input logic             busy,
    input logic             done
);
    logic        sclk_d;
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            run_q  <= '0;
        end else begin
            sclk_d <= shift_clk;
            if (shift_clk != sclk_d)  run_q <= 16'd1;
            else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
        end
    end

    // R2
    clk_high_in_load_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> shift_clk);

    // R3
    phase_width_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_clk != sclk_d) |-> (run_q >= 16'(HALF)));

    // R3
    fall_when_shifting_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_clk) |-> (load_n && busy));

    // R5
    write_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && dev_count == '0) |=> (done && !busy && !load_n));
endmodule

bind sxr_reader sxr_reader_chk #(
    .HALF  (HALF_EFF),
    .CNT_W (CNT_W)
) u_sxr_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dev_count (dev_count),
    .load_n    (load_n),
    .shift_clk (shift_clk),
    .wr_en     (wr_en),
    .busy      (busy),
    .done      (done)
);

// File: tb/sxr_reader_bench.sv
`timescale 1ns/1ps
module sxr_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_DEV    = 4;
    localparam int HALF       = 4;
    localparam int CNT_W      = $clog2(MAX_DEV + 1);
    localparam int IDX_W      = $clog2(MAX_DEV);
    localparam int CW         = 8 * MAX_DEV;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] dev_count = '0;
    logic             ser_in;
    logic             load_n, shift_clk, wr_en, busy, done;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sxr_reader #(.MAX_DEV(MAX_DEV), .HALF_CYCLES(HALF)) u_sxr_reader (
        .clk(clk), .rst(rst), .start(start), .dev_count(dev_count), .ser_in(ser_in),
        .load_n(load_n), .shift_clk(shift_clk), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    // External chain model: level capture, shifts one cycle after a rising shift clock
    logic [CW-1:0] pattern = '0;
    logic [CW-1:0] chain   = '0;
    logic          sc_prev = 1'b1;
    always @(posedge clk) begin
        sc_prev <= shift_clk;
        if (!load_n)                  chain <= pattern;
        else if (shift_clk && !sc_prev) chain <= {chain[CW-2:0], 1'b0};
    end
    assign ser_in = chain[CW-1];

    // Monitor
    logic       mon_clear = 1'b0;
    int         cyc = 0;
    int         nwr, order_bad, rises, min_run, run_len, last_wr_cyc, done_cyc, load_hi;
    logic [7:0] cap [MAX_DEV];
    logic       mon_prev;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mon_prev <= shift_clk;
        if (mon_clear) begin
            nwr <= 0; order_bad <= 0; rises <= 0; min_run <= 1000000;
            run_len <= 0; last_wr_cyc <= -10; done_cyc <= -1; load_hi <= 0;
            for (int i = 0; i < MAX_DEV; i++) cap[i] <= 8'h00;
        end else begin
            if (wr_en) begin
                cap[wr_idx] <= wr_data;
                if (int'(wr_idx) != nwr) order_bad <= order_bad + 1;
                nwr <= nwr + 1;
                last_wr_cyc <= cyc;
            end
            if (done) done_cyc <= cyc;
            if (load_n) load_hi <= load_hi + 1;
            if (shift_clk && !mon_prev) rises <= rises + 1;
            if (shift_clk == mon_prev) run_len <= run_len + 1;
            else begin
                if (run_len < min_run) min_run <= run_len;
                run_len <= 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clear = 1'b1;
        @(negedge clk); mon_clear = 1'b0;
    endtask

    function automatic logic [7:0] pat_byte(input int k);
        return pattern[CW-1-8*k -: 8];
    endfunction

    // Launch a run, check load phase, wait for done, check ending
    task automatic run_pass(input int n, input int n_eff, input bit poke_busy, input string tag);
        int lows = 0;
        int waited = 0;
        clear_mon();
        dev_count = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
        while (!load_n && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        check(lows == HALF, {tag, " R2 load low width"}, lows, HALF);
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            dev_count = CNT_W'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waited < 5000) begin
            waited++;
            @(negedge clk);
        end
        check(done == 1'b1, {tag, " R7 done seen"}, int'(done), 1);
        check(busy == 1'b0, {tag, " R7 busy low at done"}, int'(busy), 0);
        check(load_n == 1'b0 && shift_clk == 1'b1, {tag, " R6 pins at end"},
              int'({load_n, shift_clk}), 1);
        @(negedge clk);
        check(done == 1'b0, {tag, " R7 done one cycle"}, int'(done), 0);
        check(done_cyc == last_wr_cyc + 1, {tag, " R7 done after last write"},
              done_cyc - last_wr_cyc, 1);
        check(nwr == n_eff, {tag, " R5 write count"}, nwr, n_eff);
        check(order_bad == 0, {tag, " R5 index order"}, order_bad, 0);
        check(rises == 8*n_eff - 1, {tag, " R3 rising edges"}, rises, 8*n_eff - 1);
        check(min_run == HALF, {tag, " R3 phase width"}, min_run, HALF);
        for (int k = 0; k < n_eff; k++)
            check(cap[k] == pat_byte(k), {tag, " R4 R10 byte value"}, int'(cap[k]), int'(pat_byte(k)));
    endtask

    task automatic t_reset();
        check(load_n == 1'b0, "R1 load_n", int'(load_n), 0);
        check(shift_clk == 1'b1, "R1 shift_clk", int'(shift_clk), 1);
        check(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R1 flags",
              int'({busy, done, wr_en}), 0);
    endtask

    task automatic t_single();
        pattern = {8'hA5, 8'h00, 8'h00, 8'h00};
        run_pass(1, 1, 1'b0, "single");
    endtask

    task automatic t_multi();
        pattern = {8'h81, 8'h3C, 8'hF0, 8'h00};
        run_pass(3, 3, 1'b0, "multi");
    endtask

    task automatic t_full();
        pattern = {8'hFF, 8'h00, 8'h55, 8'h96};
        run_pass(4, 4, 1'b0, "full R10");
    endtask

    task automatic t_clamp();
        pattern = {8'h12, 8'h34, 8'h56, 8'h78};
        run_pass(7, MAX_DEV, 1'b0, "clamp R5");
    endtask

    task automatic t_busy_start();
        pattern = {8'hC3, 8'h7E, 8'h00, 8'h00};
        run_pass(2, 2, 1'b1, "busy R8");
        repeat (30) @(negedge clk);
        check(busy == 1'b0 && nwr == 2, "R8 no second run", nwr, 2);
    endtask

    task automatic t_zero();
        clear_mon();
        dev_count = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R9 done next cycle", int'(done), 1);
        check(busy == 1'b0, "R9 busy stays low", int'(busy), 0);
        repeat (10) @(negedge clk);
        check(load_hi == 0, "R9 no load pulse", load_hi, 0);
        check(rises == 0 && nwr == 0, "R9 no shifting or writes", rises + nwr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_full();
        t_clamp();
        t_busy_start();
        t_zero();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule